// File: doc/BRIEF.md
# Dual-Channel Serial Sample Port Model

This block is a device-side model of a two-channel converter's serial read-out port. It is written as synthesizable logic so that a host-side serial controller can be exercised against it in simulation or on a prototype. The host drives an active-low select and a serial clock. The model presents two parallel sample words on two serial data lines, and an output-enable flag shows the high-impedance condition. Conversion and analog behaviour are reduced to capturing the two sample inputs when select falls.

Select and serial clock are oversampled on the local clock `clk_i` through a synchronizer. Every edge the host makes is acted on within three local clock cycles. A frame slot counter advances on each serial clock falling edge and stops at twice the frame length. Each data line's bit is taken from a per-slot layout: two leading zeros, the twelve data bits MSB first, then zeros up to slot 16. Slots 16 to 31 carry the other channel's word in the same layout. A hold flag models the sample switch. It drops when select falls and returns to track on the first serial clock rising edge after the thirteenth falling edge.

Top module: `dual_adc_serial_model`

## Requirements
- R1: After reset, and whenever select (`cs_ni`) is high, `oe_o` is 0, `track_o` is 1 and both data lines read 0. Serial clock edges while select is high neither enable the outputs nor advance the frame.
- R2: Once a select falling edge is seen, `oe_o` becomes 1 and both data lines read 0 (first leading zero).
- R3: After the 1st serial clock falling edge both lines still read 0 (second leading zero). After falling edge n, for n from 2 to 13, line A shows bit 13-n of the A sample and line B shows bit 13-n of the B sample (bit 11 first, bit 0 after edge 13).
- R4: After falling edges 14 and 15 both lines read 0.
- R5: For falling edges 16 to 31, the slot is s = n-16 and the same layout repeats with the channels swapped. Line A carries the B sample and line B carries the A sample: zero for s of 0, 1, 14 and 15, and bit 13-s for s from 2 to 13.
- R6: After the 32nd serial clock falling edge `oe_o` is 0 and both lines read 0. Further falling edges with select still low keep the outputs disabled.
- R7: A select rising edge at any point in a frame disables the outputs at once, sets `track_o`, and makes the next frame restart from the first leading zero.
- R8: Both sample inputs are captured at the select falling edge. Changes to them during the frame do not alter the bits shifted out.
- R9: `track_o` goes to 0 at the select falling edge. It stays 0 through falling edge 13 and returns to 1 on the first serial clock rising edge after falling edge 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low select from the host |
| sclk_i | input | 1 | Serial clock from the host |
| sample_a_i | input | 12 | Channel A sample word |
| sample_b_i | input | 12 | Channel B sample word |
| sdata_a_o | output | 1 | Serial data line A (0 while disabled) |
| sdata_b_o | output | 1 | Serial data line B (0 while disabled) |
| oe_o | output | 1 | Data lines driven (0 models high impedance) |
| track_o | output | 1 | 1 when tracking, 0 while holding the sample |

## Verification
The bench sweeps a series of sample pairs, including all-ones against all-zeros. Every slot of the 32-edge frame is compared, plus three edges past the end. A design with an off-by-one slot would shift every data bit and break the leading or trailing zeros. A design without channel swapping would repeat its own word after edge 16. A counter that did not saturate would wrap around and re-enable the lines after edge 32. Samples are overwritten right after select falls, so a design that reads them live instead of from the captured copy shows the wrong bits. A frame aborted at edge 20 and then restarted catches a counter that is not cleared on deselect. The hold flag is checked after every rising edge, which exposes a release one edge early or late.

// File: rtl/dasm_pkg.sv
package dasm_pkg;

  typedef enum logic [1:0] {
    SLOT_ZERO  = 2'd0,
    SLOT_OWN   = 2'd1,
    SLOT_OTHER = 2'd2
  } slot_e;

  // what a data line shows in frame slot k
  function automatic slot_e slot_kind(int k, int frame_len, int lead, int data_w);
    int p;
    p = k % frame_len;
    if (k >= 2 * frame_len) return SLOT_ZERO;
    if (p < lead || p >= lead + data_w) return SLOT_ZERO;
    return (k < frame_len) ? SLOT_OWN : SLOT_OTHER;
  endfunction

  // word bit index shown in slot k (MSB first)
  function automatic int slot_bit(int k, int frame_len, int lead, int data_w);
    int p;
    p = k % frame_len;
    return data_w - 1 - (p - lead);
  endfunction

endpackage

// File: rtl/dasm_edge_sync.sv
module dasm_edge_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);

  // q[STAGES-1] is the synchronized level, q[STAGES] its previous value
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {(STAGES + 1){RESET_VAL}};
    else         q <= {q[STAGES-1:0], d_i};
  end

  assign rise_o = q[STAGES-1] & ~q[STAGES];
  assign fall_o = ~q[STAGES-1] & q[STAGES];

endmodule

// File: rtl/dasm_frame_ctrl.sv
module dasm_frame_ctrl #(
  parameter int CNT_MAX    = 32,
  parameter int CNT_W      = 6,
  parameter int HOLD_EDGES = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             sclk_fall_i,
  input  logic             sclk_rise_i,
  output logic [CNT_W-1:0] slot_o,
  output logic             enable_o,
  output logic             track_o
);

  localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD_EDGES);

  logic             active_q;
  logic             track_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      track_q  <= 1'b1;
      cnt_q    <= '0;
    end else if (cs_rise_i) begin
      active_q <= 1'b0;
      track_q  <= 1'b1;
      cnt_q    <= '0;
    end else if (cs_fall_i) begin
      active_q <= 1'b1;
      track_q  <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (sclk_fall_i && cnt_q != MAX_C) cnt_q <= cnt_q + CNT_W'(1);
      if (sclk_rise_i && cnt_q >= HOLD_C) track_q <= 1'b1;
    end
  end

  assign slot_o   = cnt_q;
  assign enable_o = active_q && (cnt_q != MAX_C);
  assign track_o  = track_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_C) else $error("slot counter past limit"); // R6

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cnt_q == MAX_C && !cs_rise_i) |=> (cnt_q == MAX_C && !enable_o))
    else $error("saturated frame re-enabled"); // R6

  AST_HOLD_UNTIL_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !track_q && cnt_q < HOLD_C && !cs_rise_i) |=> !track_q)
    else $error("track released early"); // R9

endmodule

// File: rtl/dasm_bit_sel.sv
module dasm_bit_sel
  import dasm_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int LEAD_ZEROS = 2,
  parameter int FRAME_LEN  = 16,
  parameter int CNT_W      = 6
) (
  input  logic [DATA_W-1:0] own_i,
  input  logic [DATA_W-1:0] other_i,
  input  logic [CNT_W-1:0]  slot_i,
  output logic              bit_o
);

  localparam int SLOTS = 1 << CNT_W;

  logic [SLOTS-1:0] frame;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam slot_e KIND = slot_kind(k, FRAME_LEN, LEAD_ZEROS, DATA_W);
    localparam int    IDX  = slot_bit(k, FRAME_LEN, LEAD_ZEROS, DATA_W);
    if (KIND == SLOT_OWN) begin : g_own
      assign frame[k] = own_i[IDX];
    end else if (KIND == SLOT_OTHER) begin : g_other
      assign frame[k] = other_i[IDX];
    end else begin : g_zero
      assign frame[k] = 1'b0;
    end
  end

  assign bit_o = frame[slot_i];

endmodule

// File: rtl/dual_adc_serial_model.sv
module dual_adc_serial_model #(
  parameter int DATA_W      = 12,
  parameter int LEAD_ZEROS  = 2,
  parameter int FRAME_LEN   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_a_i,
  input  logic [DATA_W-1:0] sample_b_i,
  output logic              sdata_a_o,
  output logic              sdata_b_o,
  output logic              oe_o,
  output logic              track_o
);

  localparam int CNT_MAX    = 2 * FRAME_LEN;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int HOLD_EDGES = LEAD_ZEROS - 1 + DATA_W;
  localparam int LANES      = 2;

  logic cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic [CNT_W-1:0]  slot;
  logic              enable;
  logic [DATA_W-1:0] word_q [LANES];
  logic [LANES-1:0]  lane_bit;

  dasm_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
    .clk_i, .rst_ni, .d_i(cs_ni), .rise_o(cs_rise), .fall_o(cs_fall)
  );

  dasm_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sclk_sync (
    .clk_i, .rst_ni, .d_i(sclk_i), .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q[0] <= '0;
      word_q[1] <= '0;
    end else if (cs_fall) begin
      word_q[0] <= sample_a_i;
      word_q[1] <= sample_b_i;
    end
  end

  dasm_frame_ctrl #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W), .HOLD_EDGES(HOLD_EDGES)) u_ctrl (
    .clk_i, .rst_ni,
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sclk_fall_i(sclk_fall), .sclk_rise_i(sclk_rise),
    .slot_o(slot), .enable_o(enable), .track_o(track_o)
  );

  // lane l shows its own word first, then the other lane's word
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dasm_bit_sel #(
      .DATA_W(DATA_W), .LEAD_ZEROS(LEAD_ZEROS), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)
    ) u_sel (
      .own_i(word_q[l]), .other_i(word_q[LANES-1-l]), .slot_i(slot), .bit_o(lane_bit[l])
    );
  end

  assign oe_o      = enable;
  assign sdata_a_o = enable & lane_bit[0];
  assign sdata_b_o = enable & lane_bit[1];

  AST_SELECT_LEADS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> (oe_o && !sdata_a_o && !sdata_b_o && !track_o))
    else $error("frame start wrong"); // R2

  AST_DESELECT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> (!oe_o && track_o)) else $error("deselect did not release"); // R7

  AST_SAMPLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_fall |=> ($stable(word_q[0]) && $stable(word_q[1])))
    else $error("captured sample moved"); // R8

endmodule

// File: tb/tb_dual_adc_serial_model.sv
module tb_dual_adc_serial_model;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic [11:0] samp_a = '0;
  logic [11:0] samp_b = '0;
  logic        sd_a, sd_b, oe, track;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  dual_adc_serial_model dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk),
    .sample_a_i(samp_a), .sample_b_i(samp_b),
    .sdata_a_o(sd_a), .sdata_b_o(sd_b), .oe_o(oe), .track_o(track)
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic exp_bit(int k, logic [11:0] own, logic [11:0] other);
    int p;
    logic [11:0] w;
    if (k >= 32) return 1'b0;
    p = k % 16;
    w = (k < 16) ? own : other;
    if (p >= 2 && p <= 13) return w[13 - p];
    return 1'b0;
  endfunction

  function automatic string tag_for(int k);
    if (k >= 32) return "R6";
    if (k >= 16) return "R5";
    if (k >= 14) return "R4";
    if (k == 2)  return "R3/R8";
    return "R3";
  endfunction

  task automatic check_idle(string req);
    chk(req, "oe", 32'(oe), 0);
    chk(req, "track", 32'(track), 1);
    chk(req, "lines", {30'd0, sd_a, sd_b}, 0);
  endtask

  // one frame: select, nfalls serial clocks, optional deselect
  task automatic run_frame(logic [11:0] a, logic [11:0] b, int nfalls);
    samp_a = a;
    samp_b = b;
    cs_n = 1'b0;
    settle();
    chk("R2", "oe at select", 32'(oe), 1);
    chk("R2", "lines at select", {30'd0, sd_a, sd_b}, 0);
    chk("R9", "hold at select", 32'(track), 0);
    // R8: inputs change after capture
    samp_a = ~a;
    samp_b = a ^ b ^ 12'h3C3;
    for (int k = 1; k <= nfalls; k++) begin
      sclk = 1'b0;
      settle();
      chk(tag_for(k), "oe", 32'(oe), (k < 32) ? 1 : 0);
      chk(tag_for(k), "line A", 32'(sd_a), 32'(exp_bit(k, a, b)));
      chk(tag_for(k), "line B", 32'(sd_b), 32'(exp_bit(k, b, a)));
      if (k == 13) chk("R9", "hold at edge 13", 32'(track), 0);
      sclk = 1'b1;
      settle();
      chk("R9", "track after rise", 32'(track), (k >= 13) ? 1 : 0);
    end
  endtask

  task automatic deselect();
    cs_n = 1'b1;
    settle();
    chk("R7", "oe after deselect", 32'(oe), 0);
    chk("R7", "track after deselect", 32'(track), 1);
    chk("R7", "lines after deselect", {30'd0, sd_a, sd_b}, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check_idle("R1");
    // serial clock while deselected
    for (int i = 0; i < 5; i++) begin
      sclk = 1'b0;
      settle();
      check_idle("R1");
      sclk = 1'b1;
      settle();
    end
    run_frame(12'hFFF, 12'h000, 35);
    deselect();
    run_frame(12'h000, 12'hFFF, 35);
    deselect();
    for (int f = 0; f < 10; f++) begin
      logic [11:0] a, b;
      a = 12'((f * 1403 + 90) % 4096);
      b = 12'((f * 2717 + 1365) % 4096);
      run_frame(a, b, 35);
      deselect();
      check_idle("R1");
    end
    // aborted frame then restart
    run_frame(12'hA5C, 12'h3B1, 20);
    deselect();
    run_frame(12'h801, 12'h7FE, 33);
    deselect();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule